// File: doc/BRIEF.md
# Sensor Oscillator Frequency Measurement Controller

This block measures how fast a sensor oscillator runs by comparing it with a reference clock. The sensor oscillator arrives as a level signal sampled by the block clock, and a rising edge of that level marks one oscillator period. The block clock itself is the high-speed reference. A one-cycle enable strobe, `ls_tick`, stands for each period of a slower reference clock. Configuration arrives as plain input fields: enable, software start, trigger select, sampling time, reference select, quick option and a 7-bit high-speed divider.

After enable the block waits a fixed settling time and then raises `ready`. A measurement may then be started by a rising edge on the software start or on the selected hardware trigger. An optional calibration phase counts divided reference ticks over 16 oscillator periods and stores that count in `cal_result`. The main window follows. With the high-speed reference, the window spans the programmed number of oscillator periods and the block counts clock cycles. With the low-speed reference, the window spans the programmed number of low-speed periods and the block counts oscillator edges. The count is placed in `result` together with a one-cycle `done` pulse.

Top module: `sosc_freq_meter`

## Requirements
- R1: `ready` stays low while `cfg_enable` is low. Once `cfg_enable` is sampled high at a clock edge, `ready` rises after exactly STARTUP_CYCLES such edges (20 by default). `ready` falls one cycle after `cfg_enable` goes low.
- R2: A rising edge of `cfg_sw_start` starts a measurement only when `ready` is high and `busy` is low. An edge seen while not ready is dropped and not remembered, and a start level held high across the rise of `ready` starts nothing. `busy` rises the cycle after the start is accepted.
- R3: With `cfg_ref_low`=0 the main window spans `cfg_smp_time` oscillator periods, and `result` equals the number of clock cycles between the oscillator rising edges that open and close the window.
- R4: With `cfg_ref_low`=1 the main window spans `cfg_smp_time` periods of `ls_tick`, and `result` equals the number of oscillator rising edges after the opening tick, up to and including the closing tick.
- R5: Before the main window, a calibration phase of 16 oscillator periods counts prescaler ticks and stores the count in `cal_result`. `cfg_quick`=1 skips this phase, leaving `cal_result` unchanged, but only when `cfg_ref_low`=1. With `cfg_ref_low`=0, calibration always runs.
- R6: The prescaler ratio is `cfg_hs_div` in high-speed mode: values 0 and 1 divide by 1, and N from 2 to 127 divides by N, so `cal_result` = floor(16·P/N) for an oscillator period of P cycles. In low-speed mode the ratio is 1 whatever `cfg_hs_div` holds.
- R7: A `cfg_smp_time` of 0 acts as a window of one period.
- R8: A rising edge on `hw_trig[cfg_trig_sel]` starts a measurement under the same conditions as R2. Edges on the other trigger inputs have no effect.
- R9: `done` is high for exactly one cycle. `result` changes only in that cycle, and `busy` is low in that cycle.
- R10: Clearing `cfg_enable` during a measurement aborts it. One cycle later `busy` and `ready` are low, no `done` is produced, and `result` keeps its old value. If `cfg_enable` falls in the same cycle as a start edge, the start is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the high-speed reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Sensor enable |
| cfg_sw_start | input | 1 | Software start; acts on its rising edge |
| cfg_trig_sel | input | 2 | Index of the hardware trigger that may start a measurement |
| cfg_smp_time | input | 4 | Window length in reference periods (0 means 1) |
| cfg_ref_low | input | 1 | 0: high-speed reference, 1: low-speed reference |
| cfg_quick | input | 1 | Skip calibration (low-speed mode only) |
| cfg_hs_div | input | 7 | Prescaler ratio for high-speed calibration |
| hw_trig | input | 4 | Hardware trigger inputs |
| sosc_lvl | input | 1 | Sampled sensor oscillator level |
| ls_tick | input | 1 | One-cycle strobe per low-speed reference period |
| ready | output | 1 | Sensor settled |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle pulse when a result is stored |
| result | output | 20 | Count from the last completed window |
| cal_result | output | 20 | Count from the last calibration phase |

## Verification
Two events can land in the same clock cycle: the fall of enable and the arrival of a start edge. The bench drives both on the same falling clock edge, while the block is ready and idle. It then requires `busy` to stay low and `done` to stay silent, so the abort path is shown to win over the start gate. The same priority is tested in a second case: enable is dropped partway through a long window, and the bench confirms that the old `result` survives and that no `done` pulse appears over the rest of the window.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_CAL_SYNC  = 3'd1,
    ST_CAL_RUN   = 3'd2,
    ST_MEAS_SYNC = 3'd3,
    ST_MEAS_RUN  = 3'd4
  } sfm_state_e;

endpackage

// File: rtl/sfm_startup.sv
module sfm_startup #(
  parameter int STARTUP_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  output logic ready_o
);

  localparam int SW = $clog2(STARTUP_CYCLES + 1);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!enable_i) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (!rdy_q) begin
      cnt_d = cnt_q + 1'b1;
      rdy_d = (cnt_q == SW'(STARTUP_CYCLES - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready_o = rdy_q;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !ready_o); // R1
  AST_READY_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(enable_i)); // R1

endmodule

// File: rtl/sfm_start_gate.sv
module sfm_start_gate #(
  parameter int NUM_TRIG = 4,
  parameter int TSEL_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable_i,
  input  logic                ready_i,
  input  logic                busy_i,
  input  logic                sw_start_i,
  input  logic [TSEL_W-1:0]   trig_sel_i,
  input  logic [NUM_TRIG-1:0] hw_trig_i,
  output logic                start_o
);

  logic                sw_q;
  logic [NUM_TRIG-1:0] hw_q;
  logic [NUM_TRIG-1:0] hw_rise;
  logic                sw_rise;
  logic                sel_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b0;
    else        sw_q <= sw_start_i;
  end

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hw_q[g] <= 1'b0;
      else        hw_q[g] <= hw_trig_i[g];
    end
    assign hw_rise[g] = hw_trig_i[g] & ~hw_q[g];
  end

  always_comb begin
    sel_rise = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (trig_sel_i == TSEL_W'(i)) sel_rise = hw_rise[i];
    end
  end

  assign sw_rise = sw_start_i & ~sw_q;
  assign start_o = enable_i & ready_i & ~busy_i & (sw_rise | sel_rise);

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (ready_i && !busy_i)); // R2

endmodule

// File: rtl/sfm_prescaler.sv
module sfm_prescaler #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lim;

  assign lim    = (ratio_i < DIV_W'(2)) ? DIV_W'(1) : ratio_i;
  assign tick_o = run_i & (cnt_q == lim - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)     cnt_d = '0;
    else if (run_i)  cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && run_i && lim > DIV_W'(1) && $stable(ratio_i)) |=> !tick_o); // R6

endmodule

// File: rtl/sfm_window_engine.sv
module sfm_window_engine
  import sfm_pkg::*;
#(
  parameter int SMP_W       = 4,
  parameter int DIV_W       = 7,
  parameter int CNT_W       = 20,
  parameter int CAL_PERIODS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic             cfg_ref_low_i,
  input  logic             cfg_quick_i,
  input  logic [SMP_W-1:0] cfg_smp_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic             sosc_lvl_i,
  input  logic             ls_tick_i,
  input  logic             div_tick_i,
  output logic             pre_clear_o,
  output logic             pre_run_o,
  output logic [DIV_W-1:0] pre_ratio_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] result_o,
  output logic [CNT_W-1:0] cal_result_o
);

  localparam int CALW  = $clog2(CAL_PERIODS + 1);
  localparam int PER_W = (SMP_W > CALW) ? SMP_W : CALW;

  sfm_state_e       state_q, state_d;
  logic             sosc_q;
  logic             mode_ls_q, mode_ls_d;
  logic [SMP_W-1:0] smp_q, smp_d;
  logic [DIV_W-1:0] ratio_q, ratio_d;
  logic [PER_W-1:0] pcnt_q, pcnt_d;
  logic [CNT_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] res_q, res_d, cal_q, cal_d;
  logic             done_q, done_d;

  logic             sosc_rise;
  logic             in_cal;
  logic             win_ev;
  logic             cnt_ev;
  logic [PER_W-1:0] target;
  logic [PER_W-1:0] pcnt_inc;
  logic [CNT_W-1:0] acc_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sosc_q <= 1'b0;
    else        sosc_q <= sosc_lvl_i;
  end

  assign sosc_rise = sosc_lvl_i & ~sosc_q;
  assign in_cal    = (state_q == ST_CAL_SYNC) || (state_q == ST_CAL_RUN);
  assign win_ev    = (!in_cal && mode_ls_q) ? ls_tick_i : sosc_rise;
  assign cnt_ev    = in_cal ? div_tick_i : (mode_ls_q ? sosc_rise : 1'b1);
  assign target    = in_cal ? PER_W'(CAL_PERIODS) : PER_W'(smp_q);
  assign pcnt_inc  = pcnt_q + 1'b1;
  assign acc_sum   = acc_q + CNT_W'(cnt_ev);

  always_comb begin
    state_d     = state_q;
    mode_ls_d   = mode_ls_q;
    smp_d       = smp_q;
    ratio_d     = ratio_q;
    pcnt_d      = pcnt_q;
    acc_d       = acc_q;
    res_d       = res_q;
    cal_d       = cal_q;
    done_d      = 1'b0;
    pre_clear_o = 1'b0;
    if (!enable_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_ls_d = cfg_ref_low_i;
            smp_d     = (cfg_smp_i == '0) ? SMP_W'(1) : cfg_smp_i;
            ratio_d   = cfg_ref_low_i ? DIV_W'(1) : cfg_div_i;
            state_d   = (cfg_ref_low_i && cfg_quick_i) ? ST_MEAS_SYNC : ST_CAL_SYNC;
          end
        end
        ST_CAL_SYNC, ST_MEAS_SYNC: begin
          if (win_ev) begin
            pcnt_d      = '0;
            acc_d       = '0;
            pre_clear_o = in_cal;
            state_d     = in_cal ? ST_CAL_RUN : ST_MEAS_RUN;
          end
        end
        ST_CAL_RUN, ST_MEAS_RUN: begin
          acc_d = acc_sum;
          if (win_ev) begin
            pcnt_d = pcnt_inc;
            if (pcnt_inc == target) begin
              if (in_cal) begin
                cal_d   = acc_sum;
                state_d = ST_MEAS_SYNC;
              end else begin
                res_d   = acc_sum;
                done_d  = 1'b1;
                state_d = ST_IDLE;
              end
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_ls_q <= 1'b0;
      smp_q     <= '0;
      ratio_q   <= '0;
      pcnt_q    <= '0;
      acc_q     <= '0;
      res_q     <= '0;
      cal_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      mode_ls_q <= mode_ls_d;
      smp_q     <= smp_d;
      ratio_q   <= ratio_d;
      pcnt_q    <= pcnt_d;
      acc_q     <= acc_d;
      res_q     <= res_d;
      cal_q     <= cal_d;
      done_q    <= done_d;
    end
  end

  assign pre_run_o    = (state_q == ST_CAL_RUN);
  assign pre_ratio_o  = ratio_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign result_o     = res_q;
  assign cal_result_o = cal_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o)); // R9
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!busy_o && !done_o)); // R10
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i)); // R2
  AST_QUICK_SKIPS_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && enable_i && cfg_ref_low_i && cfg_quick_i)
      |=> (state_q == ST_MEAS_SYNC)); // R5
  AST_HS_ALWAYS_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && enable_i && !cfg_ref_low_i)
      |=> (state_q == ST_CAL_SYNC)); // R5

endmodule

// File: rtl/sosc_freq_meter.sv
module sosc_freq_meter #(
  parameter int NUM_TRIG       = 4,
  parameter int SMP_W          = 4,
  parameter int DIV_W          = 7,
  parameter int CNT_W          = 20,
  parameter int STARTUP_CYCLES = 20,
  parameter int CAL_PERIODS    = 16,
  localparam int TSEL_W        = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_enable,
  input  logic                cfg_sw_start,
  input  logic [TSEL_W-1:0]   cfg_trig_sel,
  input  logic [SMP_W-1:0]    cfg_smp_time,
  input  logic                cfg_ref_low,
  input  logic                cfg_quick,
  input  logic [DIV_W-1:0]    cfg_hs_div,
  input  logic [NUM_TRIG-1:0] hw_trig,
  input  logic                sosc_lvl,
  input  logic                ls_tick,
  output logic                ready,
  output logic                busy,
  output logic                done,
  output logic [CNT_W-1:0]    result,
  output logic [CNT_W-1:0]    cal_result
);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_int;
  logic             start;
  logic             div_tick;
  logic             pre_clear;
  logic             pre_run;
  logic [DIV_W-1:0] pre_ratio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  sfm_startup #(
    .STARTUP_CYCLES(STARTUP_CYCLES)
  ) u_startup (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .enable_i (cfg_enable),
    .ready_o  (ready)
  );

  sfm_start_gate #(
    .NUM_TRIG (NUM_TRIG),
    .TSEL_W   (TSEL_W)
  ) u_gate (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .enable_i   (cfg_enable),
    .ready_i    (ready),
    .busy_i     (busy),
    .sw_start_i (cfg_sw_start),
    .trig_sel_i (cfg_trig_sel),
    .hw_trig_i  (hw_trig),
    .start_o    (start)
  );

  sfm_prescaler #(
    .DIV_W (DIV_W)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .clear_i (pre_clear),
    .run_i   (pre_run),
    .ratio_i (pre_ratio),
    .tick_o  (div_tick)
  );

  sfm_window_engine #(
    .SMP_W       (SMP_W),
    .DIV_W       (DIV_W),
    .CNT_W       (CNT_W),
    .CAL_PERIODS (CAL_PERIODS)
  ) u_engine (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .enable_i      (cfg_enable),
    .start_i       (start),
    .cfg_ref_low_i (cfg_ref_low),
    .cfg_quick_i   (cfg_quick),
    .cfg_smp_i     (cfg_smp_time),
    .cfg_div_i     (cfg_hs_div),
    .sosc_lvl_i    (sosc_lvl),
    .ls_tick_i     (ls_tick),
    .div_tick_i    (div_tick),
    .pre_clear_o   (pre_clear),
    .pre_run_o     (pre_run),
    .pre_ratio_o   (pre_ratio),
    .busy_o        (busy),
    .done_o        (done),
    .result_o      (result),
    .cal_result_o  (cal_result)
  );

  AST_BUSY_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(busy) |-> $past(ready)); // R2

endmodule

// File: tb/tb_sosc_freq_meter.sv
module tb_sosc_freq_meter;

  localparam int STARTUP = 20;
  localparam int P       = 8;   // oscillator period in clocks
  localparam int T       = 64;  // low-speed period in clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic        cfg_sw_start = 1'b0;
  logic [1:0]  cfg_trig_sel = '0;
  logic [3:0]  cfg_smp_time = '0;
  logic        cfg_ref_low = 1'b0;
  logic        cfg_quick = 1'b0;
  logic [6:0]  cfg_hs_div = '0;
  logic [3:0]  hw_trig = '0;
  logic        sosc_lvl = 1'b0;
  logic        ls_tick = 1'b0;
  logic        ready, busy, done;
  logic [19:0] result, cal_result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sosc_freq_meter #(
    .NUM_TRIG(4), .SMP_W(4), .DIV_W(7), .CNT_W(20),
    .STARTUP_CYCLES(STARTUP), .CAL_PERIODS(16)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_sw_start(cfg_sw_start),
    .cfg_trig_sel(cfg_trig_sel), .cfg_smp_time(cfg_smp_time), .cfg_ref_low(cfg_ref_low),
    .cfg_quick(cfg_quick), .cfg_hs_div(cfg_hs_div), .hw_trig(hw_trig),
    .sosc_lvl(sosc_lvl), .ls_tick(ls_tick), .ready(ready), .busy(busy), .done(done),
    .result(result), .cal_result(cal_result)
  );

  // Stimulus for both clocks; rises never share a cycle with ls_tick.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      sosc_lvl = (cyc % P) < (P / 2);
      ls_tick  = (cyc % T) == 3;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(input int limit, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic pulse_sw();
    @(negedge clk);
    cfg_sw_start = 1'b1;
    @(negedge clk);
    cfg_sw_start = 1'b0;
  endtask

  task automatic bring_up();
    @(negedge clk);
    cfg_enable = 1'b1;
    repeat (STARTUP + 2) @(negedge clk);
  endtask

  task automatic run_meas(input bit ls, input bit quick, input logic [6:0] div,
                          input logic [3:0] smp, input string req,
                          input longint exp_res, input longint exp_cal);
    bit seen;
    cfg_ref_low  = ls;
    cfg_quick    = quick;
    cfg_hs_div   = div;
    cfg_smp_time = smp;
    pulse_sw();
    check(busy == 1'b1, req, busy, 1);
    wait_done(5000, seen);
    check(seen, req, seen, 1);
    check(result == exp_res, req, result, exp_res);
    check(cal_result == exp_cal, req, cal_result, exp_cal);
    check(busy == 1'b0, "R9", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R9", done, 0);
  endtask

  task automatic t_reset();
    check(ready == 0 && busy == 0 && done == 0, "R1", {ready, busy, done}, 0);
    check(result == 0, "R9", result, 0);
  endtask

  task automatic t_not_ready_start();
    pulse_sw();
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R2", busy, 0);
    cfg_sw_start = 1'b1;   // held level across startup
    @(negedge clk);
    cfg_enable = 1'b1;
    repeat (STARTUP - 1) @(negedge clk);
    check(ready == 1'b0, "R1", ready, 0);
    @(negedge clk);
    check(ready == 1'b1, "R1", ready, 1);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R2", busy, 0);
    cfg_sw_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_high_speed();
    run_meas(0, 0, 7'd5, 4'd3, "R3", 3 * P, (16 * P) / 5);            // R6 divide by 5
    run_meas(0, 1, 7'd3, 4'd2, "R5", 2 * P, (16 * P) / 3);            // R5 quick ignored
    run_meas(0, 0, 7'd0, 4'd1, "R6", 1 * P, 16 * P);                  // R6 zero = 1
    run_meas(0, 0, 7'd1, 4'd0, "R7", 1 * P, 16 * P);                  // R7 smp 0 = 1
  endtask

  task automatic t_low_speed();
    run_meas(0, 0, 7'd4, 4'd1, "R6", P, (16 * P) / 4);
    run_meas(1, 1, 7'd9, 4'd2, "R5", 2 * (T / P), (16 * P) / 4);      // R5 cal skipped
    run_meas(1, 0, 7'd5, 4'd3, "R4", 3 * (T / P), 16 * P);            // R6 no div in LS
  endtask

  task automatic t_trigger();
    bit seen;
    cfg_ref_low  = 1'b0;
    cfg_smp_time = 4'd2;
    cfg_hs_div   = 7'd2;
    cfg_trig_sel = 2'd2;
    @(negedge clk); hw_trig = 4'b0010;
    @(negedge clk); hw_trig = 4'b0000;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R8", busy, 0);
    hw_trig = 4'b0100;
    @(negedge clk); hw_trig = 4'b0000;
    check(busy == 1'b1, "R8", busy, 1);
    wait_done(5000, seen);
    check(seen && result == 2 * P, "R8", result, 2 * P);
  endtask

  task automatic t_abort();
    bit seen;
    logic [19:0] old;
    old = result;
    cfg_ref_low  = 1'b0;
    cfg_smp_time = 4'd15;
    pulse_sw();
    repeat (40) @(negedge clk);
    cfg_enable = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && ready == 1'b0, "R10", {busy, ready}, 0);
    wait_done(400, seen);
    check(!seen, "R10", seen, 0);
    check(result == old, "R10", result, old);
    bring_up();
    // Same-cycle enable fall and start edge.
    @(negedge clk);
    cfg_enable   = 1'b0;
    cfg_sw_start = 1'b1;
    @(negedge clk);
    cfg_sw_start = 1'b0;
    check(busy == 1'b0, "R10", busy, 0);
    wait_done(50, seen);
    check(!seen && busy == 1'b0, "R10", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_not_ready_start();
    t_high_speed();
    t_low_speed();
    t_trigger();
    t_abort();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule